// File: doc/BRIEF.md
# Bank-Aware DRAM Command Timing Gate

This block sits between a command queue and a reduced-latency DRAM interface. Each cycle it looks at one candidate command, which is a read, a write or an auto-refresh, together with a bank index and an address. It grants the command only when every timing rule is met, and otherwise holds it for that cycle. The gate keeps a row-cycle timer for each bank and a bus-direction turnaround counter. It also keeps a record of the most recent write, so that a read returning to the same location can be held back.

The handshake is valid/ready: a command is issued on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. When the presented command is held, `stall_code_o` reports the highest-priority rule that blocks it. The queue is expected to hold the command stable, or to swap in another one, until it is granted. The gate does not reorder commands and does not decide when refresh is needed.

Top module: `dram_cmd_gate`

## Requirements
- R1: Reset (active-low, asynchronous) clears every bank timer, the turnaround state and the write record, so the first command after reset is granted in the same cycle it is presented.
- R2: When a command of any type is issued to bank b in cycle t, any further command to bank b is held with stall code 1 until cycle t+T_RC (default 4), and may be granted in that cycle.
- R3: Commands to different banks with no pending timer are granted in consecutive cycles with no idle cycle between them.
- R4: A read issued in cycle t holds a write until cycle t+T_TA+1 with stall code 2, and a write holds a read in the same way. Commands in the same direction may follow each other back to back. The default T_TA is 1.
- R5: A read to the same bank and same address as the most recent write, issued in cycle t, is held with stall code 3 until cycle t+T_WTR (default 6).
- R6: A read to a different address in the bank of a prior write is limited only by R2 and R4.
- R7: Only the most recent write is recorded. A later write to another location removes the hold that R5 placed on the earlier write's location.
- R8: When several rules apply at once, the reported code follows the priority 3 (write-to-read) over 1 (row cycle) over 2 (turnaround).
- R9: When `cmd_valid_i` is low, `stall_code_o` is 0 and nothing is issued.
- R10: Command encoding is 0 read, 1 write, 2 auto-refresh, with 3 reserved and treated as refresh. Refresh obeys R2, is exempt from R4 and R5, and does not change the turnaround state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Candidate command present |
| cmd_type_i | input | 2 | 0 read, 1 write, 2 refresh, 3 reserved (refresh) |
| cmd_bank_i | input | BANK_W (4) | Target bank |
| cmd_addr_i | input | ADDR_W (16) | Target address within bank |
| cmd_ready_o | output | 1 | No rule blocks the presented command |
| stall_code_o | output | 2 | 0 none, 1 row cycle, 2 turnaround, 3 write-to-read |

## Verification
On every cycle, the assertions check that no two grants go to the same bank on adjacent edges and that grants never switch direction on adjacent edges. They also check that a read never hits the location just written on the edge after the write, and that a refresh leaves the recorded bus direction unchanged. Only the bench's scenarios can show the exact cycle on which each hold is released, the priority among overlapping stall reasons, and the replacement of the write record by a newer write. The same applies to back-to-back grants across all 16 banks and the clearing effect of a reset issued in the middle of traffic.

// File: rtl/dram_gate_pkg.sv
package dram_gate_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_REF = 2'd2,
    CMD_RSV = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    STALL_NONE = 2'd0,
    STALL_RC   = 2'd1,
    STALL_TA   = 2'd2,
    STALL_WTR  = 2'd3
  } stall_e;

  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/gate_down_cnt.sv
module gate_down_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dram_bank_timers.sv
module dram_bank_timers #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned T_RC      = 4,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [BANK_W-1:0]    issue_bank_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  import dram_gate_pkg::*;
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(T_RC - 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    gate_down_cnt #(.W(CNT_W)) u_rc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (issue_i && (issue_bank_i == BANK_W'(g))),
      .load_val_i (RC_LOAD),
      .busy_o     (busy_o[g])
    );
  end
endmodule

// File: rtl/dram_turn_trk.sv
module dram_turn_trk #(
  parameter int unsigned T_TA = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_data_i,
  input  logic issue_wr_i,
  output logic busy_o,
  output logic last_wr_o
);
  import dram_gate_pkg::*;
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(T_TA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           last_wr_o <= 1'b0;
    else if (issue_data_i) last_wr_o <= issue_wr_i;
  end

  gate_down_cnt #(.W(CNT_W)) u_ta (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (issue_data_i),
    .load_val_i (TA_LOAD),
    .busy_o     (busy_o)
  );
endmodule

// File: rtl/dram_wtr_trk.sv
module dram_wtr_trk #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned T_WTR  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  import dram_gate_pkg::*;
  localparam logic [CNT_W-1:0] WTR_LOAD = CNT_W'(T_WTR - 1);

  logic [BANK_W-1:0] rec_bank_q;
  logic [ADDR_W-1:0] rec_addr_q;
  logic              pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_bank_q <= '0;
      rec_addr_q <= '0;
    end else if (issue_wr_i) begin
      rec_bank_q <= bank_i;
      rec_addr_q <= addr_i;
    end
  end

  gate_down_cnt #(.W(CNT_W)) u_wtr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (issue_wr_i),
    .load_val_i (WTR_LOAD),
    .busy_o     (pend)
  );

  assign hit_o = pend && (bank_i == rec_bank_q) && (addr_i == rec_addr_q);
endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
  import dram_gate_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned T_RC      = 4,
  parameter int unsigned T_WTR     = 6,
  parameter int unsigned T_TA      = 1,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_type_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              cmd_ready_o,
  output logic [1:0]        stall_code_o
);
  logic [NUM_BANKS-1:0] bank_busy;
  logic ta_busy, last_wr, wtr_hit;
  logic is_rd, is_wr, is_data, grant;
  logic rc_blk, ta_blk, wtr_blk;
  stall_e code;

  assign is_rd   = (cmd_type_i == CMD_RD);
  assign is_wr   = (cmd_type_i == CMD_WR);
  assign is_data = is_rd || is_wr;

  dram_bank_timers #(.NUM_BANKS(NUM_BANKS), .T_RC(T_RC)) u_banks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (grant),
    .issue_bank_i (cmd_bank_i),
    .busy_o       (bank_busy)
  );

  dram_turn_trk #(.T_TA(T_TA)) u_turn (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_data_i (grant && is_data),
    .issue_wr_i   (is_wr),
    .busy_o       (ta_busy),
    .last_wr_o    (last_wr)
  );

  dram_wtr_trk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .T_WTR(T_WTR)) u_wtr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_wr_i (grant && is_wr),
    .bank_i     (cmd_bank_i),
    .addr_i     (cmd_addr_i),
    .hit_o      (wtr_hit)
  );

  assign rc_blk  = bank_busy[cmd_bank_i];
  assign ta_blk  = is_data && ta_busy && (is_wr != last_wr);
  assign wtr_blk = is_rd && wtr_hit;

  // priority: write-to-read, then row cycle, then turnaround
  always_comb begin
    if (wtr_blk)     code = STALL_WTR;
    else if (rc_blk) code = STALL_RC;
    else if (ta_blk) code = STALL_TA;
    else             code = STALL_NONE;
  end

  assign cmd_ready_o  = (code == STALL_NONE);
  assign stall_code_o = cmd_valid_i ? code : STALL_NONE;
  assign grant        = cmd_valid_i && cmd_ready_o;

  if (T_RC > 1) begin : g_a_rc
    p_rc_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant |=> !(grant && (cmd_bank_i == $past(cmd_bank_i))));
  end

  if (T_TA >= 1) begin : g_a_ta
    p_turn_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant && is_data) |=> !(grant && is_data && (is_wr != $past(is_wr))));
  end

  if (T_WTR > 1) begin : g_a_wtr
    p_wtr_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant && is_wr) |=> !(grant && is_rd && (cmd_bank_i == $past(cmd_bank_i))
                             && (cmd_addr_i == $past(cmd_addr_i))));
  end

  p_ref_keeps_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !is_data) |=> $stable(last_wr));

  p_idle_no_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> (stall_code_o == STALL_NONE));
endmodule

// File: tb/dram_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_gate_tb_top;
  localparam int unsigned ADDR_W = 16;

  typedef struct packed {
    logic        v;
    logic [1:0]  t;
    logic [3:0]  b;
    logic [7:0]  a;
    logic        er;
    logic [1:0]  ec;
    logic [3:0]  req;
  } vec_t;

  // T_RC=4, T_WTR=6, T_TA=1; one entry per cycle
  localparam vec_t VECS [22] = '{
    '{1'b1, 2'd0, 4'd0, 8'd5, 1'b1, 2'd0, 4'd1},  // R1 first cmd
    '{1'b1, 2'd0, 4'd1, 8'd0, 1'b1, 2'd0, 4'd3},  // R3 other bank
    '{1'b1, 2'd1, 4'd2, 8'd7, 1'b0, 2'd2, 4'd4},  // R4 rd->wr gap
    '{1'b1, 2'd1, 4'd2, 8'd7, 1'b1, 2'd0, 4'd4},  // R4
    '{1'b1, 2'd1, 4'd3, 8'd1, 1'b1, 2'd0, 4'd4},  // R4 same dir
    '{1'b1, 2'd0, 4'd2, 8'd7, 1'b0, 2'd1, 4'd8},  // R8 rc over ta
    '{1'b1, 2'd0, 4'd2, 8'd7, 1'b0, 2'd1, 4'd2},  // R2
    '{1'b1, 2'd0, 4'd2, 8'd7, 1'b1, 2'd0, 4'd7},  // R7, R2 boundary
    '{1'b1, 2'd1, 4'd4, 8'd0, 1'b0, 2'd2, 4'd4},  // R4
    '{1'b1, 2'd1, 4'd4, 8'd0, 1'b1, 2'd0, 4'd4},  // R4
    '{1'b1, 2'd0, 4'd4, 8'd0, 1'b0, 2'd3, 4'd8},  // R8 wtr over all
    '{1'b1, 2'd0, 4'd4, 8'd9, 1'b0, 2'd1, 4'd6},  // R6
    '{1'b1, 2'd0, 4'd4, 8'd9, 1'b0, 2'd1, 4'd6},  // R6
    '{1'b1, 2'd0, 4'd4, 8'd9, 1'b1, 2'd0, 4'd6},  // R6 diff addr ok
    '{1'b1, 2'd0, 4'd4, 8'd0, 1'b0, 2'd3, 4'd5},  // R5
    '{1'b1, 2'd2, 4'd4, 8'd0, 1'b0, 2'd1, 4'd10}, // R10 refresh rc
    '{1'b1, 2'd1, 4'd6, 8'd0, 1'b1, 2'd0, 4'd4},  // R4
    '{1'b1, 2'd2, 4'd7, 8'd0, 1'b1, 2'd0, 4'd10}, // R10 no turnaround
    '{1'b1, 2'd0, 4'd8, 8'd0, 1'b1, 2'd0, 4'd10}, // R10 dir not reloaded
    '{1'b1, 2'd0, 4'd4, 8'd0, 1'b1, 2'd0, 4'd7},  // R7 record replaced
    '{1'b0, 2'd1, 4'd8, 8'd0, 1'b0, 2'd0, 4'd9},  // R9 idle
    '{1'b1, 2'd3, 4'd8, 8'd0, 1'b0, 2'd1, 4'd10}  // R10 reserved
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [1:0]        cmd_type_i = '0;
  logic [3:0]        cmd_bank_i = '0;
  logic [ADDR_W-1:0] cmd_addr_i = '0;
  logic              cmd_ready_o;
  logic [1:0]        stall_code_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dram_cmd_gate dut_i (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_type_i, .cmd_bank_i, .cmd_addr_i,
    .cmd_ready_o, .stall_code_o
  );

  task automatic drive(input logic v, input logic [1:0] t, input logic [3:0] b,
                       input logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    cmd_valid_i = v; cmd_type_i = t; cmd_bank_i = b; cmd_addr_i = a;
    #1;
  endtask

  task automatic chk(input string req, input logic er, input logic [1:0] ec);
    n_run++;
    if (cmd_ready_o !== er || stall_code_o !== ec) begin
      n_fail++;
      $display("FAIL %s: ready=%0b code=%0d expected ready=%0b code=%0d",
               req, cmd_ready_o, stall_code_o, er, ec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1 reset state", 1'b1, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    foreach (VECS[i]) begin
      drive(VECS[i].v, VECS[i].t, VECS[i].b, ADDR_W'(VECS[i].a));
      chk($sformatf("R%0d step %0d", VECS[i].req, i), VECS[i].er, VECS[i].ec);
    end

    // R1: reset in the middle of traffic clears the timers
    drive(1'b1, 2'd1, 4'd0, 16'h0);
    do_reset();
    drive(1'b1, 2'd0, 4'd0, 16'h0);
    chk("R1 after mid reset", 1'b1, 2'd0);
    do_reset();

    // R5 boundary: write at t, same-location read held until t+6
    drive(1'b1, 2'd1, 4'd9, 16'h3);
    chk("R5 write", 1'b1, 2'd0);
    for (int k = 0; k < 4; k++) drive(1'b0, 2'd0, 4'd9, 16'h3);
    drive(1'b1, 2'd0, 4'd9, 16'h3);
    chk("R5 t+5 held", 1'b0, 2'd3);
    drive(1'b1, 2'd0, 4'd9, 16'h3);
    chk("R5 t+6 granted", 1'b1, 2'd0);

    // R3: refresh every bank back to back
    for (int b = 0; b < 16; b++) begin
      drive(1'b1, 2'd2, 4'(b + 10), 16'h0);
      chk($sformatf("R3 bank %0d", (b + 10) % 16), 1'b1, 2'd0);
    end

    // R2: refresh spacing on one bank
    drive(1'b1, 2'd2, 4'd1, 16'h0);
    drive(1'b1, 2'd2, 4'd1, 16'h0);
    chk("R2 t+1 held", 1'b0, 2'd1);
    drive(1'b0, 2'd2, 4'd1, 16'h0);
    drive(1'b1, 2'd2, 4'd1, 16'h0);
    chk("R2 t+3 held", 1'b0, 2'd1);
    drive(1'b1, 2'd2, 4'd1, 16'h0);
    chk("R2 t+4 granted", 1'b1, 2'd0);

    drive(1'b0, 2'd0, 4'd0, 16'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: ready=%0b code=%0d expected run to finish",
               cmd_ready_o, stall_code_o);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule